// File: doc/BRIEF.md
# PHY Polling Arbitration Controller

This controller sits between an autonomous PHY polling engine and a host that occasionally needs direct access to PHY registers. The polling engine is switched on and off by a single enable output and reports its activity on a two-bit status input. The host raises a request and waits for a grant. If polling is still running, the controller first switches the engine off. It then waits, one poll per millisecond tick, until the status shows that the engine has stopped, and only then grants access. If the engine never stops, the controller reports an error instead.

When the host releases its request, polling is not restarted at once. An idle timer counts millisecond ticks, and only when it expires is the engine switched back on, after which the controller waits for the active status. A new host request that arrives while the timer is still running cancels it and is granted on the next cycle. A burst of host accesses therefore pays for the stop/start sequence only once. A held flag tells whether polling is currently considered off. The flag is cleared only after a restart has been confirmed.

Top module: `phy_poll_arbiter`

## Requirements
- R1: After reset, `poll_en` is 1 and `host_grant`, `host_err` and `poll_held` are 0.
- R2: A request seen while `poll_held` is 0 drives `poll_en` to 0 on the next edge. From then on, the status (delayed by SYNC_STAGES register stages) is sampled on each `ms_tick`. At the first tick where the status is not 2'b11 (2'b11 means fully active), `host_grant` and `poll_held` rise together on that edge.
- R3: If POLL_LIMIT consecutive ticks (default 1000) all see status 2'b11 during the stop wait, `host_err` rises on the POLL_LIMIT-th tick and `poll_en` returns to 1. `poll_held` stays 0 and no grant is given. `host_err` stays high until `host_req` drops and falls on the edge after that.
- R4: `host_grant` stays high while `host_req` stays high and falls on the edge after `host_req` drops. `poll_en` stays 0 while the grant is held.
- R5: After a release, `poll_en` rises on the IDLE_TICKS-th tick (default 10) counted from the release. `poll_held` stays 1 at that point.
- R6: A request that arrives while the idle timer is running cancels the timer. `host_grant` rises on the next edge without any change to `poll_en`. The next release restarts the full IDLE_TICKS count.
- R7: After re-enabling, `poll_held` falls at the first tick whose status is 2'b11.
- R8: If POLL_LIMIT ticks pass after re-enabling without status 2'b11, `poll_en` returns to 0, `poll_held` stays 1 and no timer runs. The next request is then granted on the following edge.
- R9: A request that arrives during the re-enable wait is not granted until that wait ends. After a successful re-enable, the stop sequence of R2 starts on the following edge.
- R10: `host_grant` and `host_err` are never high together, and `host_grant` is high only while `poll_held` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| host_req | input | 1 | Host asks for PHY access; held until grant or error |
| poll_status | input | 2 | Polling engine status; 2'b11 = fully active |
| poll_en | output | 1 | Enable for the polling engine |
| host_grant | output | 1 | Host may access the PHY registers |
| host_err | output | 1 | Stop wait timed out; held until request drops |
| poll_held | output | 1 | Polling is currently considered disabled |

## Verification
The bench aims at the timer boundaries. A re-enable that comes one tick early or late, or a timer that is not restarted after a cancelled hold-off, shows up as `poll_en` rising at the wrong tick count. Both timeouts are run to their full POLL_LIMIT length. A design that counts one poll too many or too few moves the error or the parking edge by a tick, and one that grants after a failed stop shows a spurious grant. A request that arrives during the re-enable wait is checked for the exact order of events: held cleared, polling stopped again, then granted. A design that grants early breaks that order.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOPPING,
    ST_GRANTED,
    ST_HOLDOFF,
    ST_STARTING,
    ST_PARKED,
    ST_FAILED
  } arb_state_e;

  // Fully active only when both status bits are set.
  function automatic logic status_active(input logic [1:0] st);
    return st == 2'b11;
  endfunction

  // Width needed to count 0..limit-1 (at least one bit).
  function automatic int unsigned count_width(input int unsigned limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/ppa_status_stage.sv
module ppa_status_stage #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] status_in,
  output logic       st_running,
  output logic       st_stopped
);
  import ppa_pkg::*;

  localparam int unsigned PW = 2 * SYNC_STAGES;

  logic [PW-1:0] pipe;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= status_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[PW-3:0], status_in};
      end
    end
  endgenerate

  assign st_running = status_active(pipe[PW-1 -: 2]);
  assign st_stopped = !st_running;

endmodule

// File: rtl/ppa_tick_counter.sv
module ppa_tick_counter #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic at_last
);
  import ppa_pkg::*;

  localparam int unsigned W = count_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (tick && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);

endmodule

// File: rtl/phy_poll_arbiter.sv
module phy_poll_arbiter #(
  parameter int unsigned POLL_LIMIT  = 1000,
  parameter int unsigned IDLE_TICKS  = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       host_req,
  input  logic [1:0] poll_status,
  output logic       poll_en,
  output logic       host_grant,
  output logic       host_err,
  output logic       poll_held
);
  import ppa_pkg::*;

  arb_state_e state;

  logic st_running, st_stopped;
  logic win_last, idle_last;
  logic win_clr, idle_clr;
  logic win_expire, idle_expire;
  logic stop_seen, run_seen;

  ppa_status_stage #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_in  (poll_status),
    .st_running (st_running),
    .st_stopped (st_stopped)
  );

  // Poll window shared by the stop and restart waits.
  assign win_clr = (state != ST_STOPPING) && (state != ST_STARTING);

  ppa_tick_counter #(.LIMIT(POLL_LIMIT)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (win_clr),
    .tick    (ms_tick),
    .at_last (win_last)
  );

  // Idle timer runs only in hold-off; leaving hold-off cancels it.
  assign idle_clr = (state != ST_HOLDOFF);

  ppa_tick_counter #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (idle_clr),
    .tick    (ms_tick),
    .at_last (idle_last)
  );

  assign win_expire  = ms_tick && win_last;
  assign idle_expire = ms_tick && idle_last;
  assign stop_seen   = ms_tick && st_stopped;
  assign run_seen    = ms_tick && st_running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      poll_en    <= 1'b1;
      host_grant <= 1'b0;
      host_err   <= 1'b0;
      poll_held  <= 1'b0;
    end else begin
      case (state)
        ST_RUN: begin
          if (host_req) begin
            state   <= ST_STOPPING;
            poll_en <= 1'b0;
          end
        end
        ST_STOPPING: begin
          if (stop_seen) begin
            state      <= ST_GRANTED;
            host_grant <= 1'b1;
            poll_held  <= 1'b1;
          end else if (win_expire) begin
            state    <= ST_FAILED;
            host_err <= 1'b1;
            poll_en  <= 1'b1;
          end
        end
        ST_GRANTED: begin
          if (!host_req) begin
            state      <= ST_HOLDOFF;
            host_grant <= 1'b0;
          end
        end
        ST_HOLDOFF: begin
          if (host_req) begin
            state      <= ST_GRANTED;
            host_grant <= 1'b1;
          end else if (idle_expire) begin
            state   <= ST_STARTING;
            poll_en <= 1'b1;
          end
        end
        ST_STARTING: begin
          if (run_seen) begin
            state     <= ST_RUN;
            poll_held <= 1'b0;
          end else if (win_expire) begin
            state   <= ST_PARKED;
            poll_en <= 1'b0;
          end
        end
        ST_PARKED: begin
          if (host_req) begin
            state      <= ST_GRANTED;
            host_grant <= 1'b1;
          end
        end
        ST_FAILED: begin
          if (!host_req) begin
            state    <= ST_RUN;
            host_err <= 1'b0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R10
  grant_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_grant && host_err));

  // R10
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> poll_held);

  // R4
  grant_pollen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> !poll_en);

  // R4
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_grant && !host_req) |=> !host_grant);

  // R7
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(poll_held) |-> $past(run_seen));

  // R3
  err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_err && host_req) |=> host_err);

endmodule

// File: tb/sim_phy_poll_arbiter.sv
module sim_phy_poll_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 8;
  localparam int POLL_LIM   = 1000;
  localparam int IDLE_LIM   = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       host_req = 1'b0;
  logic [1:0] poll_status = 2'b11;
  logic       poll_en, host_grant, host_err, poll_held;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int gap = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // Scoreboard: {grant, err, poll_en, held}, tick count, requirement tag
  logic [3:0] exp_val_q[$];
  int         exp_tick_q[$];
  string      exp_tag_q[$];
  logic [3:0] prev;

  phy_poll_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .host_req(host_req),
    .poll_status(poll_status), .poll_en(poll_en), .host_grant(host_grant),
    .host_err(host_err), .poll_held(poll_held)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      gap <= 0;
      ms_tick <= 1'b0;
      tick_cnt <= 0;
    end else begin
      gap <= (gap == TICK_GAP - 1) ? 0 : gap + 1;
      ms_tick <= (gap == TICK_GAP - 1);
      if (ms_tick) tick_cnt <= tick_cnt + 1;
    end
  end

  task automatic push(input logic g, input logic e, input logic en,
                      input logic h, input int t, input string tag);
    exp_val_q.push_back({g, e, en, h});
    exp_tick_q.push_back(t);
    exp_tag_q.push_back(tag);
  endtask

  task automatic sync_tick();
    @(posedge clk iff ms_tick);
    @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", what, act, exp);
    end
  endtask

  // Monitor: every change of the outputs must match the next expected item.
  always @(negedge clk) begin
    if (mon_on) begin
      logic [3:0] cur;
      cur = {host_grant, host_err, poll_en, poll_held};
      if (cur !== prev) begin
        checks++;
        if (exp_val_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected change actual %b expected none (R10) tick %0d",
                   cur, tick_cnt);
        end else begin
          logic [3:0] ev;
          int et;
          string tg;
          ev = exp_val_q.pop_front();
          et = exp_tick_q.pop_front();
          tg = exp_tag_q.pop_front();
          if (cur !== ev || tick_cnt != et) begin
            errors++;
            $display("FAIL %s actual %b@tick%0d expected %b@tick%0d",
                     tg, cur, tick_cnt, ev, et);
          end
        end
      end
      prev = cur;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bit(poll_en,    1'b1, "R1 poll_en");
    check_bit(host_grant, 1'b0, "R1 host_grant");
    check_bit(host_err,   1'b0, "R1 host_err");
    check_bit(poll_held,  1'b0, "R1 poll_held");
    prev = {host_grant, host_err, poll_en, poll_held};
    mon_on = 1'b1;

    // Basic access, release, timed restart (R2 R4 R5 R7)
    sync_tick();
    push(0, 0, 0, 0, tick_cnt, "R2 stop");
    host_req = 1'b1;
    @(negedge clk);
    poll_status = 2'b01;
    push(1, 0, 0, 1, tick_cnt + 1, "R2 grant");
    sync_tick();
    repeat (3) sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R4 release");
    host_req = 1'b0;
    push(0, 0, 1, 1, tick_cnt + IDLE_LIM, "R5 restart");
    repeat (IDLE_LIM) sync_tick();
    poll_status = 2'b11;
    push(0, 0, 1, 0, tick_cnt + 1, "R7 held clear");
    sync_tick();
    repeat (2) sync_tick();

    // Back-to-back: cancel hold-off (R6)
    push(0, 0, 0, 0, tick_cnt, "R2 stop");
    host_req = 1'b1;
    @(negedge clk);
    poll_status = 2'b10;
    push(1, 0, 0, 1, tick_cnt + 1, "R2 grant");
    sync_tick();
    sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R4 release");
    host_req = 1'b0;
    repeat (4) sync_tick();
    push(1, 0, 0, 1, tick_cnt, "R6 regrant");
    host_req = 1'b1;
    repeat (2) sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R6 release");
    host_req = 1'b0;
    push(0, 0, 1, 1, tick_cnt + IDLE_LIM, "R6 full restart count");
    repeat (IDLE_LIM) sync_tick();
    poll_status = 2'b11;
    push(0, 0, 1, 0, tick_cnt + 1, "R7 held clear");
    sync_tick();
    sync_tick();

    // Stop timeout (R3)
    push(0, 0, 0, 0, tick_cnt, "R2 stop");
    push(0, 1, 1, 0, tick_cnt + POLL_LIM, "R3 stop timeout");
    host_req = 1'b1;
    repeat (POLL_LIM) sync_tick();
    sync_tick();
    push(0, 0, 1, 0, tick_cnt, "R3 err release");
    host_req = 1'b0;
    repeat (2) sync_tick();

    // Restart timeout and parked grant (R8)
    push(0, 0, 0, 0, tick_cnt, "R2 stop");
    host_req = 1'b1;
    @(negedge clk);
    poll_status = 2'b00;
    push(1, 0, 0, 1, tick_cnt + 1, "R2 grant");
    sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R4 release");
    host_req = 1'b0;
    push(0, 0, 1, 1, tick_cnt + IDLE_LIM, "R5 restart");
    push(0, 0, 0, 1, tick_cnt + IDLE_LIM + POLL_LIM, "R8 park");
    repeat (IDLE_LIM + POLL_LIM) sync_tick();
    sync_tick();
    push(1, 0, 0, 1, tick_cnt, "R8 parked grant");
    host_req = 1'b1;
    repeat (2) sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R4 release");
    host_req = 1'b0;
    push(0, 0, 1, 1, tick_cnt + IDLE_LIM, "R5 restart");
    repeat (IDLE_LIM) sync_tick();

    // Request during restart wait (R9)
    host_req = 1'b1;
    repeat (2) sync_tick();
    poll_status = 2'b11;
    push(0, 0, 1, 0, tick_cnt + 1, "R9 held clear first");
    push(0, 0, 0, 0, tick_cnt + 1, "R9 stop after restart");
    sync_tick();
    poll_status = 2'b01;
    push(1, 0, 0, 1, tick_cnt + 1, "R9 grant");
    sync_tick();
    push(0, 0, 0, 1, tick_cnt, "R4 release");
    host_req = 1'b0;
    push(0, 0, 1, 1, tick_cnt + IDLE_LIM, "R5 restart");
    repeat (IDLE_LIM) sync_tick();
    poll_status = 2'b11;
    push(0, 0, 1, 0, tick_cnt + 1, "R7 held clear");
    sync_tick();
    repeat (3) sync_tick();

    checks++;
    if (exp_val_q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending events actual %0d expected 0", exp_val_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule